// File: doc/BRIEF.md
# Split-Issue Vector Shuffle Dispatcher

This block takes vector shuffle micro-ops one at a time and sends them to three 256-bit shuffle execution pipes. An op is 128, 256 or 512 bits wide. It is either in-lane, meaning its data stays inside each 128-bit lane, or cross-lane, meaning data moves between lanes. The pipes are only 256 bits wide, so a 512-bit op issues as a low half and a high half. In-lane halves may go to any free pipe and may issue in different cycles. Cross-lane work is wired only to pipes 1 and 2, and a cross-lane 512-bit op must take both of those pipes in one cycle.

The dispatcher holds at most one op. It withdraws its ready signal while that op still has a half waiting, and it never issues to a pipe that the external busy mask marks. After the last half of an op issues, a completion timer starts, with a length set by the op's class and width. Finished ops are reported as one-cycle pulses that carry the op tag. When two ops finish together, they are reported oldest first.

Top module: `shuf_dispatch`

## Requirements
- R1: `op_width` is encoded as 0 for 128 bits, 1 for 256 bits and 2 for 512 bits. A 128-bit or 256-bit op issues on exactly one pipe in one cycle, with its half bit at 0.
- R2: In-lane halves take free pipes in ascending pipe-number order, starting at pipe 0.
- R3: An in-lane 512-bit op issues its low half (half bit 0) and its high half (half bit 1) in one cycle on the two lowest free pipes. If only one pipe is free, the low half issues and the high half issues in a later cycle on the lowest free pipe.
- R4: A cross-lane op (`op_cross` = 1) never issues on pipe 0.
- R5: A cross-lane 512-bit op issues only when pipes 1 and 2 are both free. It then puts its low half on pipe 1 and its high half on pipe 2 in the same cycle, and otherwise waits.
- R6: No issue is made to a pipe whose `pipe_busy` bit is set in that cycle.
- R7: `op_ready` is high when no op is held, or when the held op issues its last half in the current cycle. An accepted op can issue at the earliest in the next cycle. Ops issue in arrival order, and an op that is offered while ready is low waits.
- R8: An in-lane op completes one cycle after the cycle in which its last half issues.
- R9: A cross-lane op completes 3, 4 or 5 cycles after the cycle in which its last half issues, for 128, 256 and 512 bits respectively.
- R10: Each completion is a `fin_valid` pulse of one cycle with the op's tag on `fin_tag`. When two ops finish in the same cycle, the older one is reported in that cycle and the younger one in the next cycle.
- R11: A synchronous reset discards the held op and all pending completions. After reset, `op_ready` is high and no issue or completion is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An op is offered |
| op_ready | output | 1 | The offered op is taken at this edge |
| op_width | input | 2 | Op width code (0: 128, 1: 256, 2: 512) |
| op_cross | input | 1 | 1 for a cross-lane op, 0 for an in-lane op |
| op_tag | input | TAG_W | Tag that identifies the op |
| pipe_busy | input | 3 | Per-pipe busy mask for this cycle |
| iss_valid | output | 3 | Per-pipe issue strobe |
| iss_half | output | 3 | Per-pipe half bit (1 = high half) |
| iss_tag | output | 3*TAG_W | Per-pipe tag, pipe p at bits p*TAG_W upward |
| fin_valid | output | 1 | One-cycle completion pulse |
| fin_tag | output | TAG_W | Tag of the completed op |

## Verification
The interesting collision is two completions that fall due in the same cycle. The bench provokes one by issuing a cross-lane 512-bit op, which waits five cycles. It then feeds a 128-bit in-lane op exactly four cycles later, so that its one-cycle wait ends in the same cycle as the first op's. It expects the cross-lane tag in that cycle, the in-lane tag in the following cycle, and no pulse in the cycle after that. A second overlap, a new op being accepted in the same cycle as the held op's last issue, is checked by offering the next op while the first one issues and confirming that it issues in the cycle directly after.

// File: rtl/shuf_pkg.sv
`timescale 1ns/1ps
package shuf_pkg;

    localparam int NPIPE = 3;
    localparam logic [NPIPE-1:0] XLANE_PIPES = 3'b110;
    localparam int LAT_W = 3;

    typedef enum logic [1:0] {
        W128 = 2'd0,
        W256 = 2'd1,
        W512 = 2'd2
    } vwidth_e;

    typedef enum logic {
        CLS_INLANE = 1'b0,
        CLS_XLANE  = 1'b1
    } vclass_e;

    typedef struct packed {
        vwidth_e width;
        vclass_e cls;
    } vop_kind_t;

    // cycles from last-half issue to completion
    function automatic logic [LAT_W-1:0] op_latency(input vop_kind_t k);
        logic [LAT_W-1:0] lat;
        if (k.cls == CLS_INLANE) begin
            lat = 3'd1;
        end else begin
            case (k.width)
                W128:    lat = 3'd3;
                W256:    lat = 3'd4;
                default: lat = 3'd5;
            endcase
        end
        return lat;
    endfunction

endpackage

// File: rtl/shuf_pick.sv
`timescale 1ns/1ps
module shuf_pick
    import shuf_pkg::*;
(
    input  logic             enable,
    input  vop_kind_t        kind,
    input  logic             lo_done,
    input  logic [NPIPE-1:0] free,
    output logic [NPIPE-1:0] grant_lo,
    output logic [NPIPE-1:0] grant_hi,
    output logic             last
);

    logic [NPIPE-1:0] allowed;
    logic [NPIPE-1:0] first;
    logic [NPIPE-1:0] rest;
    logic [NPIPE-1:0] second;

    always_comb begin
        allowed = free & ((kind.cls == CLS_XLANE) ? XLANE_PIPES : {NPIPE{1'b1}});
        first   = allowed & (~allowed + 1'b1);
        rest    = allowed & ~first;
        second  = rest & (~rest + 1'b1);

        grant_lo = '0;
        grant_hi = '0;
        last     = 1'b0;
        if (enable) begin
            if (kind.width != W512) begin
                grant_lo = first;
                last     = |first;
            end else if (kind.cls == CLS_XLANE) begin
                // both halves travel together on the lane-crossing pipes
                if (allowed == XLANE_PIPES) begin
                    grant_lo = first;
                    grant_hi = second;
                    last     = 1'b1;
                end
            end else if (!lo_done) begin
                grant_lo = first;
                grant_hi = second;
                last     = |second;
            end else begin
                grant_hi = first;
                last     = |first;
            end
        end
    end

endmodule

// File: rtl/shuf_issue_stage.sv
`timescale 1ns/1ps
module shuf_issue_stage
    import shuf_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  vop_kind_t              in_kind,
    input  logic [TAG_W-1:0]       in_tag,
    input  logic [NPIPE-1:0]       pipe_busy,
    input  logic                   room,
    output logic [NPIPE-1:0]       iss_valid,
    output logic [NPIPE-1:0]       iss_half,
    output logic [NPIPE*TAG_W-1:0] iss_tag,
    output logic                   push,
    output logic [TAG_W-1:0]       push_tag,
    output logic [LAT_W-1:0]       push_rem
);

    logic             held;
    logic             lo_done;
    vop_kind_t        kind_q;
    logic [TAG_W-1:0] tag_q;
    logic [NPIPE-1:0] grant_lo;
    logic [NPIPE-1:0] grant_hi;
    logic             last;
    logic             accept;

    shuf_pick u_pick (
        .enable   (held && room),
        .kind     (kind_q),
        .lo_done  (lo_done),
        .free     (~pipe_busy),
        .grant_lo (grant_lo),
        .grant_hi (grant_hi),
        .last     (last)
    );

    assign in_ready  = !held || last;
    assign accept    = in_valid && in_ready;
    assign iss_valid = grant_lo | grant_hi;
    assign iss_half  = grant_hi;
    assign push      = last;
    assign push_tag  = tag_q;
    assign push_rem  = op_latency(kind_q) - 1'b1;

    for (genvar p = 0; p < NPIPE; p++) begin : g_tag
        assign iss_tag[p*TAG_W +: TAG_W] = iss_valid[p] ? tag_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= 1'b0;
            lo_done <= 1'b0;
            kind_q  <= '{width: W128, cls: CLS_INLANE};
            tag_q   <= '0;
        end else if (accept) begin
            held    <= 1'b1;
            lo_done <= 1'b0;
            kind_q  <= in_kind;
            tag_q   <= in_tag;
        end else if (held && last) begin
            held    <= 1'b0;
        end else if (held && |grant_lo) begin
            lo_done <= 1'b1;
        end
    end

    assert_busy_respected_R6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid & pipe_busy) == '0);

    assert_single_half_R1: assert property (@(posedge clk) disable iff (rst)
        (held && kind_q.width != W512) |-> ($countones(iss_valid) <= 1 && iss_half == '0));

    assert_cross_no_pipe0_R4: assert property (@(posedge clk) disable iff (rst)
        (held && kind_q.cls == CLS_XLANE) |-> !iss_valid[0]);

    assert_cross_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (held && kind_q.cls == CLS_XLANE && kind_q.width == W512 && iss_valid != '0)
        |-> (iss_valid == XLANE_PIPES && iss_half == 3'b100));

    assert_hold_until_done_R7: assert property (@(posedge clk) disable iff (rst)
        (held && !in_ready) |=> (held && $stable(tag_q)));

    assert_reset_clears_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!held && iss_valid == '0));

endmodule

// File: rtl/shuf_done_queue.sv
`timescale 1ns/1ps
module shuf_done_queue
    import shuf_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [LAT_W-1:0] push_rem,
    output logic             room,
    output logic             fin_valid,
    output logic [TAG_W-1:0] fin_tag
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // entries kept in age order, index 0 oldest
    logic [LAT_W-1:0] rem  [DEPTH];
    logic [TAG_W-1:0] tag  [DEPTH];
    logic [LAT_W-1:0] nrem [DEPTH];
    logic [TAG_W-1:0] ntag [DEPTH];
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    ncnt;
    logic             hit;
    logic [IW-1:0]    sel;

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CW'(i) < cnt && rem[i] == '0) begin
                hit = 1'b1;
                sel = IW'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = i + ((hit && i >= int'(sel)) ? 1 : 0);
            if (src < DEPTH) begin
                nrem[i] = (rem[src] == '0) ? '0 : rem[src] - 1'b1;
                ntag[i] = tag[src];
            end else begin
                nrem[i] = '0;
                ntag[i] = '0;
            end
        end
        ncnt = hit ? cnt - CW'(1) : cnt;
        if (push && ncnt < CW'(DEPTH)) begin
            nrem[int'(ncnt)] = push_rem;
            ntag[int'(ncnt)] = push_tag;
            ncnt = ncnt + CW'(1);
        end
    end

    assign room      = cnt < CW'(DEPTH);
    assign fin_valid = hit;
    assign fin_tag   = tag[sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                rem[i] <= '0;
                tag[i] <= '0;
            end
        end else begin
            cnt <= ncnt;
            for (int i = 0; i < DEPTH; i++) begin
                rem[i] <= nrem[i];
                tag[i] <= ntag[i];
            end
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        push |-> room);

    assert_fin_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (fin_valid && cnt == CW'(1) && !push) |=> !fin_valid);

    assert_reset_empty_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fin_valid && cnt == '0));

endmodule

// File: rtl/shuf_dispatch.sv
`timescale 1ns/1ps
module shuf_dispatch
    import shuf_pkg::*;
#(
    parameter int TAG_W    = 6,
    parameter int CQ_DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    output logic                   op_ready,
    input  logic [1:0]             op_width,
    input  logic                   op_cross,
    input  logic [TAG_W-1:0]       op_tag,
    input  logic [NPIPE-1:0]       pipe_busy,
    output logic [NPIPE-1:0]       iss_valid,
    output logic [NPIPE-1:0]       iss_half,
    output logic [NPIPE*TAG_W-1:0] iss_tag,
    output logic                   fin_valid,
    output logic [TAG_W-1:0]       fin_tag
);

    vop_kind_t        in_kind;
    logic             push;
    logic [TAG_W-1:0] push_tag;
    logic [LAT_W-1:0] push_rem;
    logic             room;

    assign in_kind.width = vwidth_e'(op_width);
    assign in_kind.cls   = vclass_e'(op_cross);

    shuf_issue_stage #(.TAG_W(TAG_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (op_valid),
        .in_ready  (op_ready),
        .in_kind   (in_kind),
        .in_tag    (op_tag),
        .pipe_busy (pipe_busy),
        .room      (room),
        .iss_valid (iss_valid),
        .iss_half  (iss_half),
        .iss_tag   (iss_tag),
        .push      (push),
        .push_tag  (push_tag),
        .push_rem  (push_rem)
    );

    shuf_done_queue #(.TAG_W(TAG_W), .DEPTH(CQ_DEPTH)) u_done (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_tag  (push_tag),
        .push_rem  (push_rem),
        .room      (room),
        .fin_valid (fin_valid),
        .fin_tag   (fin_tag)
    );

endmodule

// File: tb/shuf_dispatch_test.sv
`timescale 1ns/1ps
module shuf_dispatch_test;

    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [1:0]    op_width = '0;
    logic          op_cross = 1'b0;
    logic [TW-1:0] op_tag = '0;
    logic [2:0]    pipe_busy = '0;
    logic [2:0]    iss_valid;
    logic [2:0]    iss_half;
    logic [3*TW-1:0] iss_tag;
    logic          fin_valid;
    logic [TW-1:0] fin_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shuf_dispatch #(.TAG_W(TW), .CQ_DEPTH(8)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_width(op_width), .op_cross(op_cross), .op_tag(op_tag),
        .pipe_busy(pipe_busy), .iss_valid(iss_valid), .iss_half(iss_half),
        .iss_tag(iss_tag), .fin_valid(fin_valid), .fin_tag(fin_tag)
    );

    typedef struct packed {
        logic [1:0] w;
        logic       x;
        logic [2:0] b0;
        logic [2:0] b1;
        logic [2:0] m1;
        logic [2:0] h1;
        logic       r1;
        logic [2:0] m2;
        logic [2:0] h2;
        logic [3:0] fin;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 3'b000, 3'b000, 3'b001, 3'b000, 1'b1, 3'b000, 3'b000, 4'd2},
        '{2'd1, 1'b0, 3'b001, 3'b000, 3'b010, 3'b000, 1'b1, 3'b000, 3'b000, 4'd2},
        '{2'd2, 1'b0, 3'b000, 3'b000, 3'b011, 3'b010, 1'b1, 3'b000, 3'b000, 4'd2},
        '{2'd2, 1'b0, 3'b011, 3'b000, 3'b100, 3'b000, 1'b0, 3'b001, 3'b001, 4'd3},
        '{2'd2, 1'b0, 3'b101, 3'b010, 3'b010, 3'b000, 1'b0, 3'b001, 3'b001, 4'd3},
        '{2'd0, 1'b1, 3'b000, 3'b000, 3'b010, 3'b000, 1'b1, 3'b000, 3'b000, 4'd4},
        '{2'd1, 1'b1, 3'b010, 3'b000, 3'b100, 3'b000, 1'b1, 3'b000, 3'b000, 4'd5},
        '{2'd2, 1'b1, 3'b000, 3'b000, 3'b110, 3'b100, 1'b1, 3'b000, 3'b000, 4'd6},
        '{2'd2, 1'b1, 3'b100, 3'b000, 3'b000, 3'b000, 1'b0, 3'b110, 3'b100, 4'd7},
        '{2'd1, 1'b1, 3'b110, 3'b001, 3'b000, 3'b000, 1'b0, 3'b010, 3'b000, 4'd6},
        '{2'd2, 1'b0, 3'b111, 3'b110, 3'b000, 3'b000, 1'b0, 3'b001, 3'b000, 4'd4},
        '{2'd0, 1'b0, 3'b111, 3'b000, 3'b000, 3'b000, 1'b0, 3'b001, 3'b000, 4'd3}
    };

    function automatic string vreq(input int i);
        case (i)
            0:       return "R1 R2";
            1:       return "R2 R6";
            2, 3, 4: return "R3 R6";
            5, 6:    return "R4 R6";
            8, 9:    return "R5 R6";
            7:       return "R5";
            default: return "R3 R6 R7";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_tags(input string req, input logic [TW-1:0] exp);
        for (int p = 0; p < 3; p++)
            if (iss_valid[p]) chk(req, "issue tag", 32'(iss_tag[p*TW +: TW]), 32'(exp));
    endtask

    task automatic offer(input logic [1:0] w, input logic x, input logic [TW-1:0] t);
        op_valid = 1'b1;
        op_width = w;
        op_cross = x;
        op_tag   = t;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R11: state after reset
        chk("R11", "ready after reset", 32'(op_ready), 32'd1);
        chk("R11", "issue after reset", 32'(iss_valid), 32'd0);
        chk("R11", "fin after reset",   32'(fin_valid), 32'd0);

        // table walk: one op per vector, two busy phases, then completion watch
        for (int v = 0; v < NV; v++) begin
            int nfin;
            int fcyc;
            logic [TW-1:0] ftag;
            string rq;
            rq = vreq(v);
            nfin = 0; fcyc = 0; ftag = '0;
            @(negedge clk);
            pipe_busy = 3'b000;
            offer(VECS[v].w, VECS[v].x, TW'(v + 1));
            for (int c = 1; c <= 10; c++) begin
                @(negedge clk);
                op_valid = 1'b0;
                pipe_busy = (c == 1) ? VECS[v].b0 : (c == 2) ? VECS[v].b1 : 3'b000;
                #1;
                if (c == 1) begin
                    chk(rq, "cycle1 pipes", 32'(iss_valid), 32'(VECS[v].m1));
                    chk(rq, "cycle1 halves", 32'(iss_half), 32'(VECS[v].h1));
                    chk("R7", "cycle1 ready", 32'(op_ready), 32'(VECS[v].r1));
                    chk_tags(rq, TW'(v + 1));
                end
                if (c == 2) begin
                    chk(rq, "cycle2 pipes", 32'(iss_valid), 32'(VECS[v].m2));
                    chk(rq, "cycle2 halves", 32'(iss_half), 32'(VECS[v].h2));
                    chk_tags(rq, TW'(v + 1));
                end
                if (fin_valid) begin
                    nfin++;
                    if (nfin == 1) begin
                        fcyc = c;
                        ftag = fin_tag;
                    end
                end
            end
            chk(VECS[v].x ? "R9" : "R8", "completion cycle", 32'(fcyc), 32'(VECS[v].fin));
            chk("R10", "completion tag", 32'(ftag), 32'(v + 1));
            chk("R10", "completion pulses", 32'(nfin), 32'd1);
        end

        // R7: next op accepted while the held one issues its last half
        @(negedge clk);
        pipe_busy = 3'b000;
        offer(2'd0, 1'b0, 6'd20);
        @(negedge clk);
        offer(2'd1, 1'b0, 6'd21);
        #1;
        chk("R7", "ready on last issue", 32'(op_ready), 32'd1);
        chk("R7", "first op pipes", 32'(iss_valid), 32'b001);
        chk_tags("R7", 6'd20);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk("R7", "second op pipes", 32'(iss_valid), 32'b001);
        chk_tags("R7", 6'd21);
        chk("R8", "first op completion", 32'(fin_valid), 32'd1);
        chk("R8", "first op fin tag", 32'(fin_tag), 32'd20);
        @(negedge clk); #1;
        chk("R8", "second op completion", 32'(fin_valid), 32'd1);
        chk("R8", "second op fin tag", 32'(fin_tag), 32'd21);

        // R7 R5: op offered while ready is low waits for the cross pair
        @(negedge clk);
        offer(2'd2, 1'b1, 6'd22);
        @(negedge clk);
        pipe_busy = 3'b100;
        offer(2'd0, 1'b0, 6'd23);
        #1;
        chk("R5", "blocked cross pair", 32'(iss_valid), 32'd0);
        chk("R7", "ready low while held", 32'(op_ready), 32'd0);
        @(negedge clk);
        pipe_busy = 3'b000;
        #1;
        chk("R5", "cross pair issues", 32'(iss_valid), 32'b110);
        chk_tags("R5", 6'd22);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk("R7", "waiting op issues next", 32'(iss_valid), 32'b001);
        chk_tags("R7", 6'd23);
        repeat (8) @(negedge clk);

        // R10: two completions due in the same cycle
        @(negedge clk);
        offer(2'd2, 1'b1, 6'd30);
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (c == 4) offer(2'd0, 1'b0, 6'd31);
            else op_valid = 1'b0;
            #1;
            if (c == 6) begin
                chk("R10", "older fin first", 32'(fin_valid), 32'd1);
                chk("R10", "older fin tag", 32'(fin_tag), 32'd30);
            end
            if (c == 7) begin
                chk("R10", "younger fin next", 32'(fin_valid), 32'd1);
                chk("R10", "younger fin tag", 32'(fin_tag), 32'd31);
            end
            if (c == 8) chk("R10", "no third fin", 32'(fin_valid), 32'd0);
        end

        // R11: reset with one op timing out and one op held
        @(negedge clk);
        offer(2'd2, 1'b1, 6'd40);
        @(negedge clk);
        offer(2'd2, 1'b0, 6'd41);
        @(negedge clk);
        op_valid = 1'b0;
        pipe_busy = 3'b111;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pipe_busy = 3'b000;
        #1;
        chk("R11", "held op dropped", 32'(iss_valid), 32'd0);
        chk("R11", "ready after mid reset", 32'(op_ready), 32'd1);
        begin
            int seen;
            seen = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk); #1;
                if (fin_valid || iss_valid != 3'b000) seen++;
            end
            chk("R11", "no activity after reset", 32'(seen), 32'd0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule